// File: doc/BRIEF.md
# Variable-Clock Delay Test Sequencer

The block drives delay tests into a non-scan sequential circuit by changing how long each test vector is given to settle. A test sequence of `NUM_VEC` vectors sits in an external vector memory. The sequencer plays the whole sequence `NUM_VEC` times. These repetitions are called passes. During pass k, vector k is given one rated-clock cycle. Every other vector is given a slow slot of `SLOW_RATIO` rated cycles. The vectors before slot k bring the circuit under test into a known state. The vectors after slot k carry any late transition out to the primary outputs, where an external observer compares them.

The sequencer runs on the rated clock. It places each vector on a registered primary-input bus and raises `tick` in the last cycle of each slot. `tick` marks the cycle whose closing edge clocks the circuit under test. `rated_sel` is high only in the one-cycle rated slot, so it serves both as the per-cycle fast/slow clock select and as the tag that says which pass is being measured. A pass index, a vector index, `busy` and `done` report progress.

The vector memory is read asynchronously. `mem_addr` always points at the vector that the next slot will apply, so the read data is ready when the slot boundary comes. A run lasts `NUM_VEC*((NUM_VEC-1)*SLOW_RATIO+1)` rated cycles. This is about `NUM_VEC` squared slow periods.

Top module: `vclk_test_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `busy`, `done`, `tick` and `rated_sel` are 0, and `pi_vec`, `pass_idx`, `vec_idx` and `mem_addr` are 0.
- R2: A `start` pulse seen at a clock edge while the sequencer is idle or done begins a run. In the next cycle, `busy`=1, `done`=0, `pass_idx`=0, `vec_idx`=0, and `pi_vec` holds the memory word at address 0.
- R3: Within every pass the vectors are applied in order, from index 0 to `NUM_VEC-1`. `pi_vec` carries the memory word for the current `vec_idx` for the whole slot, and it changes only in the cycle after a `tick`.
- R4: The slot whose `vec_idx` equals `pass_idx` lasts exactly one cycle, with `rated_sel`=1 and `tick`=1. Every other slot lasts `SLOW_RATIO` cycles, with `rated_sel`=0 throughout and `tick`=1 only in its last cycle.
- R5: The rated slot advances one position per pass. After the final slot of pass k < `NUM_VEC-1`, the next cycle is pass k+1, slot 0.
- R6: The cycle after the final `tick` of pass `NUM_VEC-1` has `busy`=0 and `done`=1. `done` stays high, and `pi_vec` keeps the last vector, until a new start. A run has `NUM_VEC*NUM_VEC` ticks in `NUM_VEC*((NUM_VEC-1)*SLOW_RATIO+1)` cycles.
- R7: `start` has no effect while `busy` is high. The slot order, slot lengths and pass order continue unchanged.
- R8: `mem_addr` is 0 when the sequencer is not busy. While busy, it is `vec_idx+1`, wrapping to 0 after `NUM_VEC-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rated clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when not busy |
| mem_addr | output | IW | Address of the next vector to apply |
| mem_rdata | input | VEC_W | Asynchronous read data from the vector memory |
| pi_vec | output | VEC_W | Primary-input drive bus |
| tick | output | 1 | Clock enable for the circuit under test (last cycle of a slot) |
| rated_sel | output | 1 | High during the one-cycle rated slot |
| pass_idx | output | IW | Current pass, equal to the rated slot position |
| vec_idx | output | IW | Index of the vector being applied |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete, held until the next start |

## Verification
A start taken at a clock edge is visible one cycle later. From then on, `pi_vec`, `vec_idx`, `pass_idx`, `rated_sel`, `tick` and `mem_addr` each have a value that is fixed by the current pass, slot and cycle-within-slot. `done` rises one cycle after the final tick. The bench walks those three nested counts arithmetically for a small configuration (4 vectors, ratio 3). At every falling edge it compares all outputs against the position it expects, so a value that shows up one cycle early or late is caught in the cycle where it happens. A second run is started from the done state and gets a stray start pulse in the middle of a pass. It must produce the identical cycle-by-cycle trace.

// File: rtl/vct_pkg.sv
package vct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } vct_state_e;
endpackage

// File: rtl/vct_rst_sync.sv
module vct_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n = sync_q;
endmodule

// File: rtl/vct_slot_timer.sv
module vct_slot_timer #(
  parameter int SLOW_RATIO = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int CW = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_RATIO - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign tick = run && (fast || (cnt_q == LAST));

  always_comb begin
    cnt_en = run || (cnt_q != '0);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // a slow slot never finishes in the cycle right after a boundary unless the ratio is 1
  AST_SLOW_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (SLOW_RATIO > 1) && run && tick |=> !(run && !fast && tick)); // R4
endmodule

// File: rtl/vct_pass_ctrl.sv
module vct_pass_ctrl
  import vct_pkg::*;
#(
  parameter int NUM_VEC = 4,
  parameter int IW      = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tick,
  output logic          busy,
  output logic          done,
  output logic          load,
  output logic          rated_sel,
  output logic [IW-1:0] pass_idx,
  output logic [IW-1:0] vec_idx,
  output logic [IW-1:0] next_addr
);
  localparam logic [IW-1:0] LAST = IW'(NUM_VEC - 1);

  vct_state_e    st_q, st_d;
  logic [IW-1:0] pass_q, pass_d;
  logic [IW-1:0] slot_q, slot_d;
  logic          ctr_en;
  logic          slot_end, run_end;

  assign slot_end = (slot_q == LAST);
  assign run_end  = slot_end && (pass_q == LAST);

  always_comb begin
    st_d   = st_q;
    pass_d = pass_q;
    slot_d = slot_q;
    load   = 1'b0;
    ctr_en = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (tick) begin
          ctr_en = 1'b1;
          if (run_end) begin
            st_d = ST_DONE;
          end else if (slot_end) begin
            pass_d = pass_q + 1'b1;
            slot_d = '0;
            load   = 1'b1;
          end else begin
            slot_d = slot_q + 1'b1;
            load   = 1'b1;
          end
        end
      end
      default: begin
        if (start) begin
          st_d   = ST_RUN;
          pass_d = '0;
          slot_d = '0;
          load   = 1'b1;
          ctr_en = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pass_q <= '0;
      slot_q <= '0;
    end else begin
      st_q <= st_d;
      if (ctr_en) begin
        pass_q <= pass_d;
        slot_q <= slot_d;
      end
    end
  end

  assign busy      = (st_q == ST_RUN);
  assign done      = (st_q == ST_DONE);
  assign rated_sel = busy && (slot_q == pass_q);
  assign pass_idx  = pass_q;
  assign vec_idx   = slot_q;
  assign next_addr = (busy && !slot_end) ? slot_q + 1'b1 : '0;

  AST_FAST_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    rated_sel |=> !rated_sel); // R4
  AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick && (vec_idx == LAST) && (pass_idx != LAST)
      |=> busy && (pass_idx == $past(pass_idx) + 1'b1) && (vec_idx == '0)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> busy && $stable(pass_idx) && $stable(vec_idx)); // R7
endmodule

// File: rtl/vct_vec_drive.sv
module vct_vec_drive #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VEC_W-1:0] din,
  output logic [VEC_W-1:0] pi_vec
);
  logic [VEC_W-1:0] pi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pi_q <= '0;
    else if (load) pi_q <= din;
  end

  assign pi_vec = pi_q;
endmodule

// File: rtl/vclk_test_seq.sv
module vclk_test_seq #(
  parameter int NUM_VEC    = 4,
  parameter int VEC_W      = 8,
  parameter int SLOW_RATIO = 3,
  parameter int IW         = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             start,
  output logic [IW-1:0]    mem_addr,
  input  logic [VEC_W-1:0] mem_rdata,
  output logic [VEC_W-1:0] pi_vec,
  output logic             tick,
  output logic             rated_sel,
  output logic [IW-1:0]    pass_idx,
  output logic [IW-1:0]    vec_idx,
  output logic             busy,
  output logic             done
);
  logic rst_n;
  logic load;

  vct_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  vct_pass_ctrl #(.NUM_VEC(NUM_VEC), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tick      (tick),
    .busy      (busy),
    .done      (done),
    .load      (load),
    .rated_sel (rated_sel),
    .pass_idx  (pass_idx),
    .vec_idx   (vec_idx),
    .next_addr (mem_addr)
  );

  vct_slot_timer #(.SLOW_RATIO(SLOW_RATIO)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .fast  (rated_sel),
    .tick  (tick)
  );

  vct_vec_drive #(.VEC_W(VEC_W)) u_drive (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .din    (mem_rdata),
    .pi_vec (pi_vec)
  );

  AST_FAST_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    rated_sel |-> tick); // R4
  AST_PI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(pi_vec)); // R3
  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tick)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tick && !rated_sel && (mem_addr == '0)); // R8
endmodule

// File: tb/sim_vclk_test_seq.sv
module sim_vclk_test_seq;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int R  = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] mem_addr;
  logic [W-1:0]  mem_rdata;
  logic [W-1:0]  pi_vec;
  logic          tick, rated_sel, busy, done;
  logic [IW-1:0] pass_idx, vec_idx;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  function automatic int vec_of(int a);
    return (a * 29 + 7) & 8'hFF;
  endfunction

  assign mem_rdata = W'(vec_of(int'(mem_addr)));

  vclk_test_seq #(.NUM_VEC(N), .VEC_W(W), .SLOW_RATIO(R), .IW(IW)) u0 (
    .clk(clk), .arst_n(arst_n), .start(start), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pi_vec(pi_vec), .tick(tick), .rated_sel(rated_sel),
    .pass_idx(pass_idx), .vec_idx(vec_idx), .busy(busy), .done(done)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_quiet(string req, int exp_done, int exp_pi);
    check(req, "busy", int'(busy), 0);
    check(req, "done", int'(done), exp_done);
    check(req, "tick", int'(tick), 0);
    check(req, "rated_sel", int'(rated_sel), 0);
    check(req, "mem_addr", int'(mem_addr), 0);
    check(req, "pi_vec", int'(pi_vec), exp_pi);
  endtask

  task automatic run_once(bit inject);
    int ticks = 0;
    int cycles = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: first cycle after start
    check("R2", "pass_idx at start", int'(pass_idx), 0);
    check("R2", "pi_vec at start", int'(pi_vec), vec_of(0));
    for (int p = 0; p < N; p++) begin
      for (int s = 0; s < N; s++) begin
        int len = (s == p) ? 1 : R;
        for (int c = 0; c < len; c++) begin
          check("R2", "busy", int'(busy), 1);
          check("R5", "pass_idx", int'(pass_idx), p);
          check("R3", "vec_idx", int'(vec_idx), s);
          check("R3", "pi_vec", int'(pi_vec), vec_of(s));
          check("R4", "rated_sel", int'(rated_sel), (s == p) ? 1 : 0);
          check("R4", "tick", int'(tick), (c == len - 1) ? 1 : 0);
          check("R8", "mem_addr", int'(mem_addr), (s == N - 1) ? 0 : s + 1);
          if (tick) ticks++;
          cycles++;
          // R7: stray start mid-pass must be ignored
          start = (inject && p == 1 && s == 2 && c == 0) ? 1'b1 : 1'b0;
          @(negedge clk);
          start = 1'b0;
        end
      end
    end
    check("R6", "tick count", ticks, N * N);
    check("R6", "run cycles", cycles, N * ((N - 1) * R + 1));
    check_quiet("R6", 1, vec_of(N - 1));
    repeat (3) @(negedge clk);
    check_quiet("R6", 1, vec_of(N - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: during reset
    check_quiet("R1", 0, 0);
    check("R1", "pass_idx", int'(pass_idx), 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R1", 0, 0);
    check("R1", "vec_idx", int'(vec_idx), 0);
    run_once(1'b0);
    run_once(1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule